// File: doc/BRIEF.md
# Profile-Based Waveform RAM Sequencer

This block plays back words from a 1024 x 32-bit waveform memory. The playback is governed by eight profiles. Each profile holds a start address, an end address and a step-rate value. Software loads the memory words and the profile registers through one write port. It then picks a playback mode, an active profile and a destination code, and raises `run_en`. While `run_en` stays high, the block walks the memory address in the way the mode calls for. Each cycle it presents the word at the current address together with that address.

There are seven legal modes. Direct select shows one fixed word. There are one-shot and continuous up-ramps, and a continuous bounce. A single up-and-down pass always uses profile 0's range. A sequence runs through profiles 0 up to the active one, either once or looping. Once `run_en` is raised, the profile registers and the destination code are frozen. Further writes to them are dropped until playback stops.

Top module: `wram_seq`

## Requirements
- R1: A write with `wr_kind`=0 stores `wr_data` at memory word `wr_addr`. In every cycle, `word_o` equals the stored word at the address shown on `addr_o`.
- R2: In a stepping mode the address moves once every 4 x rate cycles, where rate is the step-rate value of the profile currently being played (a value of 0 counts as 1). The first move comes 4 x rate cycles after playback starts.
- R3: Mode 0 (direct select) holds `addr_o` at the start address of the profile on `prof_sel`. The address follows `prof_sel` while running and never steps.
- R4: Mode 1 (one-shot ramp) steps from the active profile's start to its end. One step period after reaching the end, it holds there and raises `done_o` until `run_en` falls.
- R5: Mode 4 (continuous ramp) steps up through the active profile's range and goes from the end address back to the start address.
- R6: Mode 3 (continuous bounce) steps up to the active profile's end, then down to its start, and so on. It turns around on the step that leaves each limit.
- R7: Mode 2 (single bounce) uses profile 0's range whatever `prof_sel` is. It goes up to the end, then down to the start, then holds there with `done_o` high.
- R8: Mode 5 plays the ranges of profiles 0, 1, ... up to the active profile, each at its own rate, and then holds with `done_o` high. Mode 6 instead jumps back to profile 0's start and repeats.
- R9: Starting in mode 5 or 6 with profile 0 active, or starting in the reserved mode 7, raises `err_o` with no stepping. `err_o` clears when `run_en` falls.
- R10: While `run_en` is high or playback is active, profile writes (`wr_kind` 1 start, 2 end, 3 rate, with the profile index in `wr_addr[2:0]`) are ignored, and `dest_o` keeps its value. When idle, `dest_o` takes `dest_sel` on each clock.
- R11: Writing a start address above the profile's end address raises the end address to match. Writing an end address below the start address sets it to the start address.
- R12: After reset, `addr_o`=0, `done_o`=0, `err_o`=0 and `dest_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run_en | input | 1 | Playback enable |
| mode_sel | input | 3 | Playback mode, sampled when playback starts |
| dest_sel | input | 2 | Destination code (0 frequency, 1 phase, 2 amplitude, 3 polar) |
| prof_sel | input | 3 | Active profile index |
| wr_en | input | 1 | Write strobe |
| wr_kind | input | 2 | Write target: 0 memory, 1 start, 2 end, 3 rate |
| wr_addr | input | 10 | Memory word address, or profile index in bits 2:0 |
| wr_data | input | 32 | Memory word, or address/rate value in the low bits |
| word_o | output | 32 | Memory word at the current address |
| addr_o | output | 10 | Current playback address |
| done_o | output | 1 | One-shot ramp, single bounce or single sequence finished |
| err_o | output | 1 | Illegal start (reserved mode or sequence on profile 0) |
| dest_o | output | 2 | Latched destination code |

## Verification
The assertions assume `mode_sel` and `prof_sel` stay constant during a stepping run, except in direct select, where following `prof_sel` is the intended behaviour. They also assume the profile registers keep end at or above start. The stimulus changes inputs only on the falling clock edge. It drops `run_en` for one rising edge between cases. It writes profiles while idle, except for the deliberate writes that check R10's lock. It places every range inside the first 64 memory words, all of which are loaded with a known pattern.

// File: rtl/wseq_pkg.sv
package wseq_pkg;
    typedef enum logic [2:0] {
        PM_DIRECT    = 3'd0,
        PM_ONCE      = 3'd1,
        PM_BOUNCE0   = 3'd2,
        PM_BOUNCE_C  = 3'd3,
        PM_RAMP_C    = 3'd4,
        PM_SEQ       = 3'd5,
        PM_SEQ_C     = 3'd6,
        PM_RSVD      = 3'd7
    } play_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_HOLD  = 2'd2,
        ST_FAULT = 2'd3
    } seq_state_e;

    typedef enum logic [1:0] {
        WK_MEM   = 2'd0,
        WK_START = 2'd1,
        WK_END   = 2'd2,
        WK_RATE  = 2'd3
    } wr_kind_e;
endpackage

// File: rtl/wseq_ram.sv
module wseq_ram #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata_o
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [DATA_W-1:0] word_d, word_q;

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    always_comb begin
        word_d = mem[raddr];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) word_q <= '0;
        else        word_q <= word_d;
    end

    assign rdata_o = word_q;
endmodule

// File: rtl/wseq_profiles.sv
module wseq_profiles #(
    parameter int NPROF  = 8,
    parameter int PROF_W = 3,
    parameter int ADDR_W = 10,
    parameter int RATE_W = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         busy_i,
    input  logic                         wr_en,
    input  logic [1:0]                   wr_kind,
    input  logic [PROF_W-1:0]            wr_prof,
    input  logic [ADDR_W-1:0]            pos_i,
    input  logic [RATE_W-1:0]            rate_i,
    output logic [NPROF-1:0][ADDR_W-1:0] start_o,
    output logic [NPROF-1:0][ADDR_W-1:0] end_o,
    output logic [NPROF-1:0][RATE_W-1:0] rate_o
);
    import wseq_pkg::*;

    typedef struct packed {
        logic [NPROF-1:0][ADDR_W-1:0] st;
        logic [NPROF-1:0][ADDR_W-1:0] en;
        logic [NPROF-1:0][RATE_W-1:0] rt;
    } prof_regs_t;

    prof_regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        for (int i = 0; i < NPROF; i++) begin
            if (wr_en && !busy_i && (wr_prof == PROF_W'(i))) begin
                case (wr_kind_e'(wr_kind))
                    WK_START: begin
                        regs_d.st[i] = pos_i;
                        if (pos_i > regs_q.en[i]) regs_d.en[i] = pos_i;
                    end
                    WK_END: begin
                        regs_d.en[i] = (pos_i < regs_q.st[i]) ? regs_q.st[i] : pos_i;
                    end
                    WK_RATE: regs_d.rt[i] = rate_i;
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign start_o = regs_q.st;
    assign end_o   = regs_q.en;
    assign rate_o  = regs_q.rt;

    for (genvar g = 0; g < NPROF; g++) begin : g_chk
        a_r11_range_order: assert property (@(posedge clk) disable iff (!rst_n)
            regs_q.en[g] >= regs_q.st[g]);
        a_r10_profile_locked: assert property (@(posedge clk) disable iff (!rst_n)
            busy_i |=> ($stable(regs_q.st[g]) && $stable(regs_q.en[g]) && $stable(regs_q.rt[g])));
    end
endmodule

// File: rtl/wseq_tick.sv
module wseq_tick #(
    parameter int RATE_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_i,
    input  logic [RATE_W-1:0] rate_i,
    output logic              tick_o
);
    localparam int CNT_W = RATE_W + 2;
    localparam logic [CNT_W-1:0]  CNT_ONE  = 1;
    localparam logic [RATE_W-1:0] RATE_ONE = 1;

    logic [CNT_W-1:0]  cnt_d, cnt_q;
    logic [RATE_W-1:0] rate_eff;
    logic [CNT_W-1:0]  lim;

    always_comb begin
        rate_eff = (rate_i == '0) ? RATE_ONE : rate_i;
        lim      = {rate_eff, 2'b00} - CNT_ONE;
        tick_o   = run_i && (cnt_q == lim);
        if (!run_i || tick_o) cnt_d = '0;
        else                  cnt_d = cnt_q + CNT_ONE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    a_r2_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);
endmodule

// File: rtl/wseq_ctrl.sv
module wseq_ctrl #(
    parameter int NPROF  = 8,
    parameter int PROF_W = 3,
    parameter int ADDR_W = 10
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         run_en,
    input  logic [2:0]                   mode_sel,
    input  logic [PROF_W-1:0]            prof_sel,
    input  logic [NPROF-1:0][ADDR_W-1:0] start_i,
    input  logic [NPROF-1:0][ADDR_W-1:0] end_i,
    input  logic                         tick_i,
    output logic [ADDR_W-1:0]            addr_o,
    output logic [ADDR_W-1:0]            addr_nx_o,
    output logic [PROF_W-1:0]            play_prof_o,
    output logic                         run_o,
    output logic                         busy_o,
    output logic                         done_o,
    output logic                         err_o
);
    import wseq_pkg::*;

    localparam logic [ADDR_W-1:0] A_ONE = 1;
    localparam logic [PROF_W-1:0] P_ONE = 1;

    typedef struct packed {
        seq_state_e          st;
        play_mode_e          mode;
        logic [PROF_W-1:0]   act;
        logic [PROF_W-1:0]   idx;
        logic                dir_dn;
        logic [ADDR_W-1:0]   addr;
    } ctrl_t;

    ctrl_t cur_q, nxt_d;
    play_mode_e        req_mode;
    logic [PROF_W-1:0] pp;
    logic [ADDR_W-1:0] lo, hi;
    logic              is_seq;

    always_comb begin
        is_seq = (cur_q.mode == PM_SEQ) || (cur_q.mode == PM_SEQ_C);
        if (cur_q.mode == PM_BOUNCE0) pp = '0;
        else if (is_seq)              pp = cur_q.idx;
        else                          pp = cur_q.act;
        lo = start_i[pp];
        hi = end_i[pp];
    end

    always_comb begin
        req_mode = play_mode_e'(mode_sel);
        nxt_d    = cur_q;
        case (cur_q.st)
            ST_IDLE: begin
                if (run_en) begin
                    nxt_d.mode   = req_mode;
                    nxt_d.act    = prof_sel;
                    nxt_d.idx    = '0;
                    nxt_d.dir_dn = 1'b0;
                    if ((req_mode == PM_RSVD) ||
                        (((req_mode == PM_SEQ) || (req_mode == PM_SEQ_C)) && (prof_sel == '0))) begin
                        nxt_d.st = ST_FAULT;
                    end else begin
                        nxt_d.st = ST_RUN;
                        if ((req_mode == PM_BOUNCE0) || (req_mode == PM_SEQ) || (req_mode == PM_SEQ_C))
                            nxt_d.addr = start_i[0];
                        else
                            nxt_d.addr = start_i[prof_sel];
                    end
                end
            end
            ST_RUN: begin
                if (!run_en) begin
                    nxt_d.st = ST_IDLE;
                end else if (cur_q.mode == PM_DIRECT) begin
                    nxt_d.addr = start_i[prof_sel];
                end else if (tick_i) begin
                    case (cur_q.mode)
                        PM_ONCE: begin
                            if (cur_q.addr == hi) nxt_d.st = ST_HOLD;
                            else                  nxt_d.addr = cur_q.addr + A_ONE;
                        end
                        PM_RAMP_C: begin
                            nxt_d.addr = (cur_q.addr == hi) ? lo : cur_q.addr + A_ONE;
                        end
                        PM_BOUNCE0: begin
                            if (!cur_q.dir_dn) begin
                                if (cur_q.addr == hi) begin
                                    if (hi == lo) begin
                                        nxt_d.st = ST_HOLD;
                                    end else begin
                                        nxt_d.dir_dn = 1'b1;
                                        nxt_d.addr   = cur_q.addr - A_ONE;
                                    end
                                end else begin
                                    nxt_d.addr = cur_q.addr + A_ONE;
                                end
                            end else begin
                                if (cur_q.addr == lo) nxt_d.st = ST_HOLD;
                                else                  nxt_d.addr = cur_q.addr - A_ONE;
                            end
                        end
                        PM_BOUNCE_C: begin
                            if (!cur_q.dir_dn) begin
                                if (cur_q.addr == hi) begin
                                    nxt_d.dir_dn = 1'b1;
                                    nxt_d.addr   = (hi == lo) ? cur_q.addr : cur_q.addr - A_ONE;
                                end else begin
                                    nxt_d.addr = cur_q.addr + A_ONE;
                                end
                            end else begin
                                if (cur_q.addr == lo) begin
                                    nxt_d.dir_dn = 1'b0;
                                    nxt_d.addr   = (hi == lo) ? cur_q.addr : cur_q.addr + A_ONE;
                                end else begin
                                    nxt_d.addr = cur_q.addr - A_ONE;
                                end
                            end
                        end
                        PM_SEQ, PM_SEQ_C: begin
                            if (cur_q.addr == hi) begin
                                if (cur_q.idx == cur_q.act) begin
                                    if (cur_q.mode == PM_SEQ) begin
                                        nxt_d.st = ST_HOLD;
                                    end else begin
                                        nxt_d.idx  = '0;
                                        nxt_d.addr = start_i[0];
                                    end
                                end else begin
                                    nxt_d.idx  = cur_q.idx + P_ONE;
                                    nxt_d.addr = start_i[cur_q.idx + P_ONE];
                                end
                            end else begin
                                nxt_d.addr = cur_q.addr + A_ONE;
                            end
                        end
                        default: ;
                    endcase
                end
            end
            ST_HOLD, ST_FAULT: begin
                if (!run_en) nxt_d.st = ST_IDLE;
            end
            default: nxt_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign addr_o      = cur_q.addr;
    assign addr_nx_o   = nxt_d.addr;
    assign play_prof_o = pp;
    assign run_o       = (cur_q.st == ST_RUN);
    assign busy_o      = run_en || (cur_q.st != ST_IDLE);
    assign done_o      = (cur_q.st == ST_HOLD);
    assign err_o       = (cur_q.st == ST_FAULT);

    a_r4_hold_sticks: assert property (@(posedge clk) disable iff (!rst_n)
        ((cur_q.st == ST_HOLD) && run_en) |=> ((cur_q.st == ST_HOLD) && $stable(cur_q.addr)));
    a_r9_fault_no_step: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.st == ST_FAULT) |=> $stable(cur_q.addr));
    a_r8_seq_index_bound: assert property (@(posedge clk) disable iff (!rst_n)
        ((cur_q.st == ST_RUN) && is_seq) |-> (cur_q.idx <= cur_q.act));
    a_r5_range_kept: assert property (@(posedge clk) disable iff (!rst_n)
        ((cur_q.st == ST_RUN) && (cur_q.mode != PM_DIRECT) && $stable(start_i) && $stable(end_i))
            |-> ((cur_q.addr >= lo) && (cur_q.addr <= hi)));
endmodule

// File: rtl/wram_seq.sv
module wram_seq #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 32,
    parameter int NPROF  = 8,
    parameter int RATE_W = 16,
    localparam int PROF_W = $clog2(NPROF)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_en,
    input  logic [2:0]        mode_sel,
    input  logic [1:0]        dest_sel,
    input  logic [PROF_W-1:0] prof_sel,
    input  logic              wr_en,
    input  logic [1:0]        wr_kind,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] word_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              done_o,
    output logic              err_o,
    output logic [1:0]        dest_o
);
    import wseq_pkg::*;

    logic [NPROF-1:0][ADDR_W-1:0] prof_start, prof_end;
    logic [NPROF-1:0][RATE_W-1:0] prof_rate;
    logic [ADDR_W-1:0]            addr_nx;
    logic [PROF_W-1:0]            play_prof;
    logic                         running, busy, tick;
    logic [1:0]                   dest_d, dest_q;

    wseq_profiles #(.NPROF(NPROF), .PROF_W(PROF_W), .ADDR_W(ADDR_W), .RATE_W(RATE_W)) prof_i (
        .clk(clk), .rst_n(rst_n), .busy_i(busy), .wr_en(wr_en), .wr_kind(wr_kind),
        .wr_prof(wr_addr[PROF_W-1:0]), .pos_i(wr_data[ADDR_W-1:0]), .rate_i(wr_data[RATE_W-1:0]),
        .start_o(prof_start), .end_o(prof_end), .rate_o(prof_rate)
    );

    wseq_tick #(.RATE_W(RATE_W)) tick_i (
        .clk(clk), .rst_n(rst_n), .run_i(running), .rate_i(prof_rate[play_prof]), .tick_o(tick)
    );

    wseq_ctrl #(.NPROF(NPROF), .PROF_W(PROF_W), .ADDR_W(ADDR_W)) ctrl_i (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .mode_sel(mode_sel), .prof_sel(prof_sel),
        .start_i(prof_start), .end_i(prof_end), .tick_i(tick),
        .addr_o(addr_o), .addr_nx_o(addr_nx), .play_prof_o(play_prof),
        .run_o(running), .busy_o(busy), .done_o(done_o), .err_o(err_o)
    );

    wseq_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) ram_i (
        .clk(clk), .rst_n(rst_n), .we(wr_en && (wr_kind_e'(wr_kind) == WK_MEM)),
        .waddr(wr_addr), .wdata(wr_data), .raddr(addr_nx), .rdata_o(word_o)
    );

    always_comb begin
        dest_d = busy ? dest_q : dest_sel;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dest_q <= '0;
        else        dest_q <= dest_d;
    end

    assign dest_o = dest_q;

    a_r10_dest_locked: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(dest_q));
    a_r9_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> !done_o);
endmodule

// File: tb/wram_seq_tb_top.sv
module wram_seq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 17;

    typedef struct packed {
        logic [2:0] mode;
        logic [2:0] prof;
        logic [7:0] w;
        logic [9:0] addr;
        logic       done;
        logic       err;
    } vec_t;

    localparam vec_t VECS [NV] = '{
        '{3'd1, 3'd1, 8'd4,  10'd21, 1'b0, 1'b0},
        '{3'd1, 3'd1, 8'd12, 10'd22, 1'b1, 1'b0},
        '{3'd1, 3'd1, 8'd40, 10'd22, 1'b1, 1'b0},
        '{3'd4, 3'd1, 8'd12, 10'd20, 1'b0, 1'b0},
        '{3'd4, 3'd1, 8'd16, 10'd21, 1'b0, 1'b0},
        '{3'd3, 3'd1, 8'd12, 10'd21, 1'b0, 1'b0},
        '{3'd3, 3'd1, 8'd16, 10'd20, 1'b0, 1'b0},
        '{3'd3, 3'd1, 8'd20, 10'd21, 1'b0, 1'b0},
        '{3'd2, 3'd1, 8'd12, 10'd13, 1'b0, 1'b0},
        '{3'd2, 3'd1, 8'd24, 10'd10, 1'b0, 1'b0},
        '{3'd2, 3'd1, 8'd28, 10'd10, 1'b1, 1'b0},
        '{3'd0, 3'd2, 8'd8,  10'd30, 1'b0, 1'b0},
        '{3'd5, 3'd2, 8'd28, 10'd30, 1'b0, 1'b0},
        '{3'd5, 3'd2, 8'd48, 10'd31, 1'b1, 1'b0},
        '{3'd6, 3'd1, 8'd28, 10'd10, 1'b0, 1'b0},
        '{3'd5, 3'd0, 8'd4,  10'd0,  1'b0, 1'b1},
        '{3'd7, 3'd1, 8'd4,  10'd0,  1'b0, 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run_en = 1'b0;
    logic [2:0]  mode_sel = '0;
    logic [1:0]  dest_sel = '0;
    logic [2:0]  prof_sel = '0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_kind = '0;
    logic [9:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] word_o;
    logic [9:0]  addr_o;
    logic        done_o, err_o;
    logic [1:0]  dest_o;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wram_seq dut_i (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .mode_sel(mode_sel), .dest_sel(dest_sel),
        .prof_sel(prof_sel), .wr_en(wr_en), .wr_kind(wr_kind), .wr_addr(wr_addr), .wr_data(wr_data),
        .word_o(word_o), .addr_o(addr_o), .done_o(done_o), .err_o(err_o), .dest_o(dest_o)
    );

    function automatic logic [31:0] wfun(input logic [9:0] a);
        return 32'hC300_0000 | ({22'd0, a} * 32'd4099);
    endfunction

    function automatic string mode_tag(input logic [2:0] m, input logic e);
        if (e) return "R9";
        case (m)
            3'd0: return "R3";
            3'd1: return "R4";
            3'd2: return "R7";
            3'd3: return "R6";
            3'd4: return "R5";
            default: return "R8";
        endcase
    endfunction

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] kind, input logic [9:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_kind = kind; wr_addr = a; wr_data = d;
        step(1);
        wr_en = 1'b0;
    endtask

    task automatic start_run(input logic [2:0] m, input logic [2:0] p, input int w);
        run_en = 1'b0;
        step(1);
        mode_sel = m; prof_sel = p; run_en = 1'b1;
        step(1 + w);
    endtask

    initial begin
        step(2);
        rst_n = 1'b1;
        step(1);
        chk("R12 addr", 32'(addr_o), 32'd0);
        chk("R12 done", 32'(done_o), 32'd0);
        chk("R12 err", 32'(err_o), 32'd0);
        chk("R12 dest", 32'(dest_o), 32'd0);

        for (int a = 0; a < 64; a++) wr(2'd0, 10'(a), wfun(10'(a)));
        wr(2'd1, 10'd0, 32'd10); wr(2'd2, 10'd0, 32'd13); wr(2'd3, 10'd0, 32'd1);
        wr(2'd1, 10'd1, 32'd20); wr(2'd2, 10'd1, 32'd22); wr(2'd3, 10'd1, 32'd1);
        wr(2'd1, 10'd2, 32'd30); wr(2'd2, 10'd2, 32'd31); wr(2'd3, 10'd2, 32'd2);
        wr(2'd1, 10'd3, 32'd40); wr(2'd2, 10'd3, 32'd40); wr(2'd3, 10'd3, 32'd1);

        for (int k = 0; k < NV; k++) begin
            start_run(VECS[k].mode, VECS[k].prof, int'(VECS[k].w));
            chk(mode_tag(VECS[k].mode, VECS[k].err), 32'(err_o), 32'(VECS[k].err));
            chk(mode_tag(VECS[k].mode, VECS[k].err), 32'(done_o), 32'(VECS[k].done));
            if (!VECS[k].err) begin
                chk(mode_tag(VECS[k].mode, 1'b0), 32'(addr_o), 32'(VECS[k].addr));
                chk("R1 word", word_o, wfun(VECS[k].addr));
            end
        end

        run_en = 1'b0;
        step(1);
        chk("R9 err clears", 32'(err_o), 32'd0);

        start_run(3'd1, 3'd1, 3);
        chk("R2 before first step", 32'(addr_o), 32'd20);
        start_run(3'd4, 3'd2, 7);
        chk("R2 rate 2 early", 32'(addr_o), 32'd30);
        step(1);
        chk("R2 rate 2 step", 32'(addr_o), 32'd31);

        start_run(3'd0, 3'd2, 2);
        chk("R3 direct", 32'(addr_o), 32'd30);
        prof_sel = 3'd1;
        step(1);
        chk("R3 follows select", 32'(addr_o), 32'd20);
        chk("R1 word direct", word_o, wfun(10'd20));

        run_en = 1'b0;
        dest_sel = 2'd1;
        step(2);
        chk("R10 idle dest", 32'(dest_o), 32'd1);
        start_run(3'd0, 3'd1, 1);
        dest_sel = 2'd2;
        wr(2'd1, 10'd1, 32'd50);
        step(2);
        chk("R10 dest locked", 32'(dest_o), 32'd1);
        start_run(3'd0, 3'd1, 1);
        chk("R10 start locked", 32'(addr_o), 32'd20);

        run_en = 1'b0;
        step(1);
        wr(2'd1, 10'd3, 32'd45);
        start_run(3'd1, 3'd3, 0);
        chk("R11 start moved", 32'(addr_o), 32'd45);
        step(4);
        chk("R11 end raised", 32'(done_o), 32'd1);
        run_en = 1'b0;
        step(1);
        wr(2'd2, 10'd3, 32'd2);
        start_run(3'd4, 3'd3, 8);
        chk("R11 end clamped", 32'(addr_o), 32'd45);

        run_en = 1'b0;
        step(2);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule